// File: doc/BRIEF.md
# Command/Indication Status Channel Monitor

This block sits beside the frame extractor of a time-multiplexed serial link. Each frame carries two short status fields in each direction, and this block handles both. The extractor gives the block the received bits of both fields and a one-cycle strobe once per frame. The block checks each received field for a change, keeps the accepted codes where a host can read them, and raises one interrupt line when a change is waiting. In the other direction it holds the codes the host wrote and presents them on every frame.

The primary field is 4 bits wide. A received change on it must be seen on two strobes in a row before it is accepted. A second accepted change waits in a one-entry holding slot behind the visible one. The secondary field is 4 or 6 bits wide and accepts any change at once. Its change flag can be held back by an enable bit. The host reads the primary status word, which carries both change flags. That read clears both flags and brings forward any waiting primary code.

Top module: `cim_mon`

## Requirements
- R1: After reset, st0_code, st1_code and tx_c0 are 0, both change flags and irq are 0, tx_c1 is 6'b110000 (narrow width, enable clear).
- R2: On a frame_stb cycle, a primary code is accepted only if rx_c0 equals the value sampled at the previous strobe and differs from the last accepted code. Without a strobe, rx_c0 has no effect. Acceptance shows on st0_code and st0_chg0 right after the accepting edge.
- R3: tx_c0 takes wr_c0_data on the edge where wr_c0_en is high and keeps it until the next such write.
- R4: wr_c1_en loads wr_c1_data, wr_c1_wide and wr_c1_ien together. With wide set, tx_c1 is wr_c1_data. With wide clear, tx_c1[3:0] is wr_c1_data[3:0] and tx_c1[5:4] is 2'b11.
- R5: On a strobe, any difference between the received secondary code and st1_code updates st1_code and marks a change at that edge, with no two-frame check. In narrow mode, rx_c1[5:4] is ignored and st1_code[5:4] reads 0.
- R6: st0_chg1 is shown only while the enable is set. A change marked while the enable is clear appears on st0_chg1 once the enable is written to 1.
- R7: A cycle with rd_c0_stb high clears st0_chg0 and a shown st0_chg1 at that edge. The values presented during that cycle are the read result.
- R8: If a second primary change is accepted while st0_chg0 is set, st0_code keeps the first code. After the read, st0_code holds the second code and st0_chg0 and irq are set again.
- R9: If further primary changes are accepted while a code is already waiting, the newest one replaces the waiting code.
- R10: irq is high exactly when st0_chg0 or st0_chg1 is high.
- R11: When a read and an accepting strobe fall in the same cycle, the read is applied first. A waiting code moves forward and the new code becomes the waiting one; otherwise the new code is loaded with st0_chg0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe marking the frame's receive bits as valid |
| rx_c0 | input | 4 | Received primary field of this frame |
| rx_c1 | input | 6 | Received secondary field of this frame |
| wr_c0_en | input | 1 | Write strobe for the primary transmit code |
| wr_c0_data | input | 4 | Primary transmit code to write |
| wr_c1_en | input | 1 | Write strobe for the secondary transmit register |
| wr_c1_data | input | 6 | Secondary transmit code to write |
| wr_c1_wide | input | 1 | Width select written with the secondary register (1 = 6 bits) |
| wr_c1_ien | input | 1 | Secondary change-flag enable written with the secondary register |
| rd_c0_stb | input | 1 | Read of the primary status word; clears flags |
| st0_code | output | 4 | Accepted primary receive code |
| st0_chg0 | output | 1 | Primary change flag |
| st0_chg1 | output | 1 | Secondary change flag (gated by enable) |
| st1_code | output | 6 | Current secondary receive code |
| tx_c0 | output | 4 | Primary transmit field, repeated every frame |
| tx_c1 | output | 6 | Secondary transmit field, repeated every frame |
| irq | output | 1 | Change interrupt |

## Verification
The status read and an accepting frame strobe can land on the same edge. In that case the read's dequeue and the new code's enqueue into the two-entry primary buffer both act at once. The bench drives both in one cycle, once with the holding slot empty and once with it full. It judges the result by the code captured during the read and by the codes returned from the reads that follow. A secondary change that lands on a read edge while its enable is clear is also provoked, and the held-back flag is then checked to appear only when the enable is written.

// File: rtl/cim_pkg.sv
`timescale 1ns/1ps
package cim_pkg;
    parameter int C0_W     = 4;
    parameter int C1_W     = 6;
    parameter int NARROW_W = 4;
    localparam int EXT_W   = C1_W - NARROW_W;

    typedef struct packed {
        logic [C0_W-1:0] prev;       // value sampled at previous strobe
        logic [C0_W-1:0] last;       // most recently accepted code
        logic [C0_W-1:0] code;       // visible code
        logic            flag;       // visible change flag
        logic            pend_vld;   // second buffer entry valid
        logic [C0_W-1:0] pend_code;  // second buffer entry
    } rx0_st_t;

    typedef struct packed {
        logic [C1_W-1:0] code;
        logic            pend;       // change seen, not yet cleared
    } rx1_st_t;

    typedef struct packed {
        logic [C0_W-1:0] c0;
        logic [C1_W-1:0] c1;
        logic            wide;
        logic            ien;
    } tx_st_t;
endpackage

// File: rtl/cim_tx.sv
`timescale 1ns/1ps
module cim_tx
    import cim_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_c0_en,
    input  logic [C0_W-1:0] wr_c0_data,
    input  logic            wr_c1_en,
    input  logic [C1_W-1:0] wr_c1_data,
    input  logic            wr_c1_wide,
    input  logic            wr_c1_ien,
    output logic [C0_W-1:0] tx_c0,
    output logic [C1_W-1:0] tx_c1,
    output logic            wide,
    output logic            ien
);
    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_c0_en) begin
            st_d.c0 = wr_c0_data;
        end
        if (wr_c1_en) begin
            st_d.c1   = wr_c1_data;
            st_d.wide = wr_c1_wide;
            st_d.ien  = wr_c1_ien;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_c0 = st_q.c0;
    assign wide  = st_q.wide;
    assign ien   = st_q.ien;

    generate
        if (EXT_W > 0) begin : g_ext
            assign tx_c1 = st_q.wide ? st_q.c1
                                     : {{EXT_W{1'b1}}, st_q.c1[NARROW_W-1:0]};
        end else begin : g_noext
            assign tx_c1 = st_q.c1;
        end
    endgenerate
endmodule

// File: rtl/cim_rx0.sv
`timescale 1ns/1ps
module cim_rx0
    import cim_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stb,
    input  logic [C0_W-1:0] rx,
    input  logic            rd,
    output logic [C0_W-1:0] code,
    output logic            flag
);
    rx0_st_t st_d, st_q;
    logic    accept;

    assign accept = stb && (rx == st_q.prev) && (rx != st_q.last);

    always_comb begin
        st_d = st_q;
        // read first: dequeue the visible entry
        if (rd) begin
            if (st_q.pend_vld) begin
                st_d.code     = st_q.pend_code;
                st_d.flag     = 1'b1;
                st_d.pend_vld = 1'b0;
            end else begin
                st_d.flag = 1'b0;
            end
        end
        if (stb) begin
            st_d.prev = rx;
        end
        // then enqueue a newly accepted code
        if (accept) begin
            st_d.last = rx;
            if (st_d.flag) begin
                st_d.pend_vld  = 1'b1;
                st_d.pend_code = rx;
            end else begin
                st_d.code = rx;
                st_d.flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;
    assign flag = st_q.flag;
endmodule

// File: rtl/cim_rx1.sv
`timescale 1ns/1ps
module cim_rx1
    import cim_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stb,
    input  logic [C1_W-1:0] rx,
    input  logic            wide,
    input  logic            ien,
    input  logic            rd,
    output logic [C1_W-1:0] code,
    output logic            flag
);
    rx1_st_t         st_d, st_q;
    logic [C1_W-1:0] masked;

    generate
        if (EXT_W > 0) begin : g_mask
            assign masked = wide ? rx : {{EXT_W{1'b0}}, rx[NARROW_W-1:0]};
        end else begin : g_nomask
            assign masked = rx;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        // a read clears only a flag that is being shown
        if (rd && ien) begin
            st_d.pend = 1'b0;
        end
        if (stb && (masked != st_q.code)) begin
            st_d.code = masked;
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;
    assign flag = st_q.pend & ien;
endmodule

// File: rtl/cim_mon.sv
`timescale 1ns/1ps
module cim_mon
    import cim_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_stb,
    input  logic [C0_W-1:0] rx_c0,
    input  logic [C1_W-1:0] rx_c1,
    input  logic            wr_c0_en,
    input  logic [C0_W-1:0] wr_c0_data,
    input  logic            wr_c1_en,
    input  logic [C1_W-1:0] wr_c1_data,
    input  logic            wr_c1_wide,
    input  logic            wr_c1_ien,
    input  logic            rd_c0_stb,
    output logic [C0_W-1:0] st0_code,
    output logic            st0_chg0,
    output logic            st0_chg1,
    output logic [C1_W-1:0] st1_code,
    output logic [C0_W-1:0] tx_c0,
    output logic [C1_W-1:0] tx_c1,
    output logic            irq
);
    logic wide;
    logic ien;

    cim_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_c0_en   (wr_c0_en),
        .wr_c0_data (wr_c0_data),
        .wr_c1_en   (wr_c1_en),
        .wr_c1_data (wr_c1_data),
        .wr_c1_wide (wr_c1_wide),
        .wr_c1_ien  (wr_c1_ien),
        .tx_c0      (tx_c0),
        .tx_c1      (tx_c1),
        .wide       (wide),
        .ien        (ien)
    );

    cim_rx0 u_rx0 (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (frame_stb),
        .rx    (rx_c0),
        .rd    (rd_c0_stb),
        .code  (st0_code),
        .flag  (st0_chg0)
    );

    cim_rx1 u_rx1 (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (frame_stb),
        .rx    (rx_c1),
        .wide  (wide),
        .ien   (ien),
        .rd    (rd_c0_stb),
        .code  (st1_code),
        .flag  (st0_chg1)
    );

    assign irq = st0_chg0 | st0_chg1;
endmodule

// File: rtl/cim_mon_chk.sv
`timescale 1ns/1ps
module cim_mon_chk
    import cim_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            frame_stb,
    input logic            wr_c0_en,
    input logic            wr_c1_en,
    input logic            wr_c1_wide,
    input logic            rd_c0_stb,
    input logic [C0_W-1:0] st0_code,
    input logic            st0_chg1,
    input logic [C0_W-1:0] tx_c0,
    input logic [C1_W-1:0] tx_c1
);
    // primary code moves only after a strobe or a read
    assert_code_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st0_code) |-> ($past(frame_stb) || $past(rd_c0_stb)));

    // transmit code is held between writes
    assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_c0) |-> $past(wr_c0_en));

    // narrow write forces the upper transmit bits high
    assert_narrow_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_c1_en) && !$past(wr_c1_wide)) |-> (tx_c1[C1_W-1:NARROW_W] == '1));

    // secondary flag appears only from a frame or an enable write
    assert_chg1_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st0_chg1) |-> ($past(frame_stb) || $past(wr_c1_en)));

    // a read with no competing event drops the secondary flag
    assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c0_stb && !frame_stb && !wr_c1_en) |=> !st0_chg1);
endmodule

bind cim_mon cim_mon_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_stb  (frame_stb),
    .wr_c0_en   (wr_c0_en),
    .wr_c1_en   (wr_c1_en),
    .wr_c1_wide (wr_c1_wide),
    .rd_c0_stb  (rd_c0_stb),
    .st0_code   (st0_code),
    .st0_chg1   (st0_chg1),
    .tx_c0      (tx_c0),
    .tx_c1      (tx_c1)
);

// File: tb/cim_mon_tb.sv
`timescale 1ns/1ps
module cim_mon_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic [3:0] rx_c0 = '0;
    logic [5:0] rx_c1 = '0;
    logic       wr_c0_en = 1'b0;
    logic [3:0] wr_c0_data = '0;
    logic       wr_c1_en = 1'b0;
    logic [5:0] wr_c1_data = '0;
    logic       wr_c1_wide = 1'b0;
    logic       wr_c1_ien = 1'b0;
    logic       rd_c0_stb = 1'b0;
    logic [3:0] st0_code;
    logic       st0_chg0;
    logic       st0_chg1;
    logic [5:0] st1_code;
    logic [3:0] tx_c0;
    logic [5:0] tx_c1;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [3:0] rd_code;
    logic       rd_f0, rd_f1;

    always #5 clk = ~clk;

    cim_mon u_dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_c0(rx_c0), .rx_c1(rx_c1),
        .wr_c0_en(wr_c0_en), .wr_c0_data(wr_c0_data), .wr_c1_en(wr_c1_en),
        .wr_c1_data(wr_c1_data), .wr_c1_wide(wr_c1_wide), .wr_c1_ien(wr_c1_ien),
        .rd_c0_stb(rd_c0_stb), .st0_code(st0_code), .st0_chg0(st0_chg0),
        .st0_chg1(st0_chg1), .st1_code(st1_code), .tx_c0(tx_c0), .tx_c1(tx_c1), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic frame(input logic [3:0] c0, input logic [5:0] c1);
        @(negedge clk);
        frame_stb = 1'b1; rx_c0 = c0; rx_c1 = c1;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic rd0();
        @(negedge clk);
        rd_code = st0_code; rd_f0 = st0_chg0; rd_f1 = st0_chg1;
        rd_c0_stb = 1'b1;
        @(negedge clk);
        rd_c0_stb = 1'b0;
    endtask

    task automatic rd_frame(input logic [3:0] c0, input logic [5:0] c1);
        @(negedge clk);
        rd_code = st0_code; rd_f0 = st0_chg0; rd_f1 = st0_chg1;
        rd_c0_stb = 1'b1; frame_stb = 1'b1; rx_c0 = c0; rx_c1 = c1;
        @(negedge clk);
        rd_c0_stb = 1'b0; frame_stb = 1'b0;
    endtask

    task automatic wr0(input logic [3:0] v);
        @(negedge clk);
        wr_c0_en = 1'b1; wr_c0_data = v;
        @(negedge clk);
        wr_c0_en = 1'b0;
    endtask

    task automatic wr1(input logic [5:0] d, input logic w, input logic e);
        @(negedge clk);
        wr_c1_en = 1'b1; wr_c1_data = d; wr_c1_wide = w; wr_c1_ien = e;
        @(negedge clk);
        wr_c1_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 st0_code", st0_code, 0);
        check("R1 st0_chg0", st0_chg0, 0);
        check("R1 st0_chg1", st0_chg1, 0);
        check("R1 irq", irq, 0);
        check("R1 st1_code", st1_code, 0);
        check("R1 tx_c0", tx_c0, 0);
        check("R1 tx_c1", tx_c1, 6'b110000);

        // R3 transmit code sweep, held across frames
        for (int v = 0; v < 16; v++) begin
            wr0(v[3:0]);
            check("R3 tx_c0 after write", tx_c0, v);
            frame(4'd0, 6'd0);
            check("R3 tx_c0 held", tx_c0, v);
        end

        // R4 secondary transmit sweep in both widths
        for (int w = 0; w < 2; w++) begin
            for (int d = 0; d < 64; d++) begin
                wr1(d[5:0], w[0], 1'b0);
                check("R4 tx_c1", tx_c1, (w == 1) ? d : (48 + (d % 16)));
            end
        end
        wr1(6'd0, 1'b1, 1'b1);

        // R2 two-frame acceptance sweep, R7 read clears, R10 irq
        for (int v = 1; v < 16; v++) begin
            frame(v[3:0], 6'd0);
            check("R2 single frame no accept flag", st0_chg0, 0);
            check("R2 single frame code kept", st0_code, v - 1);
            frame(v[3:0], 6'd0);
            check("R2 accepted code", st0_code, v);
            check("R2 accepted flag", st0_chg0, 1);
            check("R10 irq on change", irq, 1);
            rd0();
            check("R7 read returns code", rd_code, v);
            check("R7 read returns flag", rd_f0, 1);
            check("R7 flag cleared", st0_chg0, 0);
            check("R10 irq cleared", irq, 0);
        end
        // R2 alternating values never accepted
        frame(4'd5, 6'd0); frame(4'd6, 6'd0); frame(4'd5, 6'd0);
        check("R2 alternating no accept", st0_chg0, 0);
        check("R2 alternating code", st0_code, 15);
        frame(4'd15, 6'd0); frame(4'd15, 6'd0);
        check("R2 same as accepted no flag", st0_chg0, 0);
        // R2 no strobe: rx ignored
        @(negedge clk); rx_c0 = 4'd3;
        repeat (4) @(negedge clk);
        check("R2 no strobe ignored", st0_code, 15);
        check("R2 no strobe flag", st0_chg0, 0);

        // R8 two-entry buffer
        frame(4'd2, 6'd0); frame(4'd2, 6'd0);
        frame(4'd9, 6'd0); frame(4'd9, 6'd0);
        check("R8 first code kept", st0_code, 2);
        rd0();
        check("R8 read gets first", rd_code, 2);
        check("R8 second loaded", st0_code, 9);
        check("R8 flag re-raised", st0_chg0, 1);
        check("R8 irq re-raised", irq, 1);
        rd0();
        check("R8 second read", rd_code, 9);
        check("R8 flag clear after second", st0_chg0, 0);

        // R9 newest replaces waiting code
        frame(4'd4, 6'd0); frame(4'd4, 6'd0);
        frame(4'd7, 6'd0); frame(4'd7, 6'd0);
        frame(4'd11, 6'd0); frame(4'd11, 6'd0);
        rd0();
        check("R9 read first", rd_code, 4);
        check("R9 newest waiting", st0_code, 11);
        check("R9 flag", st0_chg0, 1);
        rd0();
        check("R9 flag clear", st0_chg0, 0);

        // R11 coincident read and accept, empty slot
        frame(4'd6, 6'd0);
        rd_frame(4'd6, 6'd0);
        check("R11 empty slot read flag", rd_f0, 0);
        check("R11 empty slot code", st0_code, 6);
        check("R11 empty slot flag", st0_chg0, 1);
        rd0();
        // R11 coincident read and accept, full slot
        frame(4'd1, 6'd0); frame(4'd1, 6'd0);
        frame(4'd8, 6'd0); frame(4'd8, 6'd0);
        frame(4'd13, 6'd0);
        rd_frame(4'd13, 6'd0);
        check("R11 full slot read", rd_code, 1);
        check("R11 full slot moved", st0_code, 8);
        check("R11 full slot flag", st0_chg0, 1);
        rd0();
        check("R11 new code waiting", st0_code, 13);
        check("R11 new code flag", st0_chg0, 1);
        rd0();
        check("R11 drained", st0_chg0, 0);

        // R5 wide secondary sweep, single frame suffices
        for (int v = 1; v < 64; v++) begin
            frame(4'd13, v[5:0]);
            check("R5 wide code", st1_code, v);
            check("R5 wide flag", st0_chg1, 1);
            check("R10 irq secondary", irq, 1);
            rd0();
            check("R7 secondary read flag", rd_f1, 1);
            check("R7 secondary cleared", st0_chg1, 0);
        end
        frame(4'd13, 6'd63);
        check("R5 unchanged no flag", st0_chg1, 0);

        // R5 narrow mode
        wr1(6'd0, 1'b0, 1'b1);
        frame(4'd13, 6'd63);
        check("R5 narrow masked code", st1_code, 15);
        check("R5 narrow width change flag", st0_chg1, 1);
        rd0();
        frame(4'd13, 6'h2F);
        check("R5 narrow upper ignored flag", st0_chg1, 0);
        check("R5 narrow upper ignored code", st1_code, 15);
        frame(4'd13, 6'h25);
        check("R5 narrow low change code", st1_code, 5);
        check("R5 narrow low change flag", st0_chg1, 1);
        rd0();

        // R6 enable gating
        wr1(6'd0, 1'b0, 1'b0);
        frame(4'd13, 6'd9);
        check("R6 held code", st1_code, 9);
        check("R6 held flag hidden", st0_chg1, 0);
        check("R6 held irq low", irq, 0);
        rd0();
        check("R6 read shows no flag", rd_f1, 0);
        wr1(6'd0, 1'b0, 1'b1);
        check("R6 flag shown on enable", st0_chg1, 1);
        check("R6 irq on enable", irq, 1);
        rd0();
        check("R6 cleared after read", st0_chg1, 0);
        // R6 change hidden while read coincides
        wr1(6'd0, 1'b0, 1'b0);
        rd_frame(4'd13, 6'd3);
        check("R6 coincident hidden", st0_chg1, 0);
        wr1(6'd0, 1'b0, 1'b1);
        check("R6 coincident shown", st0_chg1, 1);
        check("R4 tx_c1 narrow zero", tx_c1, 6'b110000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule